// File: doc/BRIEF.md
# Hashed Page Table Group Search

This block looks up one virtual page in a group of page-table entries held in memory. A single start pulse supplies the group's base address, the table being searched (primary or secondary), the expected tag and whether the access is a write. The block then reads every entry of the group through a simple request/response memory port, two words per entry. It compares each entry against the request and finishes with a one-cycle done pulse and a status: hit, miss or inconsistent.

Two entry layouts are handled. A mode input selects one for the whole search. In the narrow layout each entry is two 32-bit words. In the wide layout each entry is two 64-bit words. The valid bit, the hash-select bit and the tag mask sit in different places in the two layouts. The search does not stop at the first match. Each later match must agree with the first one on the page-number field and on the low attribute bits. If a later match disagrees, the search ends as inconsistent. On a hit, the reference flag is set, and the change flag is set as well for a write. If this alters the word, the new second word is written back to the winning entry.

Top module: `hpt_group_search`

## Requirements
- R1: After reset, done is low, mem_req is low, status is 0 and real_word is all ones.
- R2: A group has 8 entries. Entry i starts at base + 8*i in narrow mode (mode64=0) and at base + 16*i in wide mode. Its second word lies 4 bytes (narrow) or 8 bytes (wide) after the first. Each word is one read request, held with a steady address until mem_rvalid. The first word is read before the second.
- R3: In narrow mode only mem_rdata[31:0] is used. The valid bit is bit 31 of the first word, the hash-select bit is bit 6, and the tag is the first word ANDed with 0x7FFFFFBF.
- R4: In wide mode the valid bit is bit 0 of the first word, the hash-select bit is bit 1, and the tag is the first word ANDed with 0xFFFFFFFFFFFFFF80. Bits that matter only in narrow mode have no effect here.
- R5: An entry matches only when it is valid, its hash-select bit equals tbl_sel and its tag equals exp_tag. If no entry of the group matches, status is 2 (miss) and real_word is all ones, after all 16 reads.
- R6: The first matching entry supplies the real-address word and is the write-back target. The scan still reads all 8 entries.
- R7: A later match is inconsistent if its second word differs from the first match's second word under the check mask. In narrow mode the mask is 0xFFFFF07B; in wide mode it is ~0xFFF | 0x7F (page field above bit 12). An inconsistent match ends the search at once with status 3, real_word all ones and no write. Matches that differ only outside the mask count as consistent.
- R8: On a hit the updated word is the first match's second word with bit 8 (reference) set, and with bit 7 (change) also set when is_write=1. If it differs from the stored word, exactly one write of it goes to that entry's second-word address. status is 1 (hit) and real_word is the updated word.
- R9: done is a one-cycle pulse. status and real_word hold their values until the next start. A start clears status to 0 and real_word to all ones, so no earlier result carries into a new search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a search (taken in idle) |
| base_addr | input | ADDR_W | Byte address of the group |
| tbl_sel | input | 1 | Requested table: 0 primary, 1 secondary |
| exp_tag | input | WORD_W | Expected masked tag |
| is_write | input | 1 | Access is a store (sets change flag) |
| mode64 | input | 1 | 1 selects the wide entry layout |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write (one-cycle, no response) |
| mem_addr | output | ADDR_W | Request byte address |
| mem_wdata | output | WORD_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | WORD_W | Read data |
| done | output | 1 | Search finished (one cycle) |
| status | output | 2 | 0 none, 1 hit, 2 miss, 3 inconsistent |
| real_word | output | WORD_W | Winning second word, all ones if none |

## Verification
The assertions assume that mem_rvalid answers only a pending read, for one cycle. They also assume that base_addr leaves room for a whole group below the top of the address space, and that start is raised only while the block is idle. The bench memory model raises mem_rvalid one cycle after it sees a read request and never during a write. It places every group at a low address. The bench pulses start only after the previous done and its checks are complete.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
   typedef enum logic [1:0] {
      HPT_NONE   = 2'd0,
      HPT_HIT    = 2'd1,
      HPT_MISS   = 2'd2,
      HPT_INCONS = 2'd3
   } hpt_status_e;

   localparam int          NV_VALID_BIT = 31;
   localparam int          NV_HASH_BIT  = 6;
   localparam logic [31:0] NV_TAG_MASK  = 32'h7FFF_FFBF;
   localparam logic [6:0]  NV_CHK_LOW   = 7'h7B;

   localparam int          WD_VALID_BIT = 0;
   localparam int          WD_HASH_BIT  = 1;
   localparam logic [63:0] WD_TAG_MASK  = 64'hFFFF_FFFF_FFFF_FF80;
   localparam logic [6:0]  WD_CHK_LOW   = 7'h7F;

   localparam int REF_BIT = 8;
   localparam int CHG_BIT = 7;
endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
   parameter int ADDR_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  logic              second,
   input  logic              mode64,
   output logic [ADDR_W-1:0] addr
);
   localparam int NV_SHIFT = 3;
   localparam int WD_SHIFT = 4;

   logic [ADDR_W-1:0] stride_off;
   logic [ADDR_W-1:0] word_off;

   always_comb begin
      stride_off = mode64 ? (ADDR_W'(idx) << WD_SHIFT) : (ADDR_W'(idx) << NV_SHIFT);
      word_off   = second ? (mode64 ? ADDR_W'(8) : ADDR_W'(4)) : '0;
      addr       = base + stride_off + word_off;
   end
endmodule

// File: rtl/hpt_entry_eval.sv
module hpt_entry_eval
   import hpt_pkg::*;
#(
   parameter int WORD_W     = 64,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              mode64,
   input  logic              tbl_sel,
   input  logic [WORD_W-1:0] exp_tag,
   input  logic [WORD_W-1:0] w0,
   input  logic [WORD_W-1:0] w1_new,
   input  logic [WORD_W-1:0] w1_ref,
   input  logic              ref_valid,
   output logic              match,
   output logic              conflict
);
   localparam logic [63:0] PAGE_FIELD = {64{1'b1}} << PAGE_SHIFT;
   localparam logic [63:0] NV_CHK = {32'h0, PAGE_FIELD[31:0] | {25'h0, NV_CHK_LOW}};
   localparam logic [63:0] WD_CHK = PAGE_FIELD | {57'h0, WD_CHK_LOW};

   logic              ent_valid;
   logic              ent_hash;
   logic [WORD_W-1:0] ent_tag;
   logic [WORD_W-1:0] chk_mask;

   always_comb begin
      if (mode64) begin
         ent_valid = w0[WD_VALID_BIT];
         ent_hash  = w0[WD_HASH_BIT];
         ent_tag   = w0 & WD_TAG_MASK;
         chk_mask  = WD_CHK;
      end else begin
         ent_valid = w0[NV_VALID_BIT];
         ent_hash  = w0[NV_HASH_BIT];
         ent_tag   = {32'h0, w0[31:0] & NV_TAG_MASK};
         chk_mask  = NV_CHK;
      end
      match    = ent_valid && (ent_hash == tbl_sel) && (ent_tag == exp_tag);
      conflict = match && ref_valid && (((w1_new ^ w1_ref) & chk_mask) != '0);
   end
endmodule

// File: rtl/hpt_flag_upd.sv
module hpt_flag_upd
   import hpt_pkg::*;
#(
   parameter int WORD_W = 64
) (
   input  logic [WORD_W-1:0] word_in,
   input  logic              is_write,
   output logic [WORD_W-1:0] word_out,
   output logic              changed
);
   always_comb begin
      word_out          = word_in;
      word_out[REF_BIT] = 1'b1;
      if (is_write) word_out[CHG_BIT] = 1'b1;
      changed = (word_out != word_in);
   end
endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
   import hpt_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int WORD_W     = 64,
   parameter int ENTRIES    = 8,
   parameter int PAGE_SHIFT = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              tbl_sel,
   input  logic [WORD_W-1:0] exp_tag,
   input  logic              is_write,
   input  logic              mode64,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] mem_wdata,
   input  logic              mem_rvalid,
   input  logic [WORD_W-1:0] mem_rdata,
   output logic              done,
   output logic [1:0]        status,
   output logic [WORD_W-1:0] real_word
);
   localparam int IDX_W = $clog2(ENTRIES);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

   if (WORD_W != 64) begin : g_bad_word
      $error("hpt_group_search: WORD_W must be 64");
   end
   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("hpt_group_search: ENTRIES must be a power of two >= 2");
   end
   if (PAGE_SHIFT < 9 || PAGE_SHIFT > 30) begin : g_bad_page
      $error("hpt_group_search: PAGE_SHIFT must sit above the flag bits");
   end

   typedef enum logic [2:0] {S_IDLE, S_RD0, S_RD1, S_FIN, S_WB, S_DONE} st_e;

   st_e               st_q;
   logic [IDX_W-1:0]  idx_q, win_q;
   logic [ADDR_W-1:0] base_q;
   logic [WORD_W-1:0] tag_q, w0_q, raddr_q, real_q;
   logic              tbl_q, wr_q, mode_q, found_q;
   hpt_status_e       status_q;

   logic [WORD_W-1:0] rd_word, upd_word;
   logic              ent_match, ent_conflict, upd_changed;

   assign rd_word = mode_q ? mem_rdata : {32'h0, mem_rdata[31:0]};

   hpt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) addr_i (
      .base   (base_q),
      .idx    ((st_q == S_WB) ? win_q : idx_q),
      .second ((st_q == S_RD1) || (st_q == S_WB)),
      .mode64 (mode_q),
      .addr   (mem_addr)
   );

   hpt_entry_eval #(.WORD_W(WORD_W), .PAGE_SHIFT(PAGE_SHIFT)) eval_i (
      .mode64    (mode_q),
      .tbl_sel   (tbl_q),
      .exp_tag   (tag_q),
      .w0        (w0_q),
      .w1_new    (rd_word),
      .w1_ref    (raddr_q),
      .ref_valid (found_q),
      .match     (ent_match),
      .conflict  (ent_conflict)
   );

   hpt_flag_upd #(.WORD_W(WORD_W)) flag_i (
      .word_in  (raddr_q),
      .is_write (wr_q),
      .word_out (upd_word),
      .changed  (upd_changed)
   );

   assign mem_req   = (st_q == S_RD0) || (st_q == S_RD1) || (st_q == S_WB);
   assign mem_we    = (st_q == S_WB);
   assign mem_wdata = raddr_q;
   assign done      = (st_q == S_DONE);
   assign status    = status_q;
   assign real_word = real_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= S_IDLE;
         idx_q    <= '0;
         win_q    <= '0;
         base_q   <= '0;
         tag_q    <= '0;
         w0_q     <= '0;
         raddr_q  <= '1;
         real_q   <= '1;
         tbl_q    <= 1'b0;
         wr_q     <= 1'b0;
         mode_q   <= 1'b0;
         found_q  <= 1'b0;
         status_q <= HPT_NONE;
      end else begin
         unique case (st_q)
            S_IDLE: if (start) begin
               base_q   <= base_addr;
               tag_q    <= exp_tag;
               tbl_q    <= tbl_sel;
               wr_q     <= is_write;
               mode_q   <= mode64;
               idx_q    <= '0;
               found_q  <= 1'b0;
               raddr_q  <= '1;
               real_q   <= '1;
               status_q <= HPT_NONE;
               st_q     <= S_RD0;
            end
            S_RD0: if (mem_rvalid) begin
               w0_q <= rd_word;
               st_q <= S_RD1;
            end
            S_RD1: if (mem_rvalid) begin
               if (ent_conflict) begin
                  status_q <= HPT_INCONS;
                  real_q   <= '1;
                  st_q     <= S_DONE;
               end else begin
                  if (ent_match && !found_q) begin
                     found_q <= 1'b1;
                     raddr_q <= rd_word;
                     win_q   <= idx_q;
                  end
                  if (idx_q == LAST_IDX) begin
                     st_q <= S_FIN;
                  end else begin
                     idx_q <= idx_q + 1'b1;
                     st_q  <= S_RD0;
                  end
               end
            end
            S_FIN: begin
               if (!found_q) begin
                  status_q <= HPT_MISS;
                  real_q   <= '1;
                  st_q     <= S_DONE;
               end else if (upd_changed) begin
                  raddr_q <= upd_word;
                  st_q    <= S_WB;
               end else begin
                  status_q <= HPT_HIT;
                  real_q   <= raddr_q;
                  st_q     <= S_DONE;
               end
            end
            S_WB: begin
               status_q <= HPT_HIT;
               real_q   <= raddr_q;
               st_q     <= S_DONE;
            end
            default: st_q <= S_IDLE;
         endcase
      end
   end

   // R2: a pending read keeps its address until data returns
   a_r2_read_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_we && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

   // R2: every request stays inside the current group
   a_r2_addr_in_group: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> ((mem_addr - base_q) < ADDR_W'(ENTRIES * 16)));

   // R5: a miss never reports a real word
   a_r5_miss_word: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd2) |-> (real_word == '1));

   // R7: an inconsistent search ends without a write just before it
   a_r7_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd3) |-> !$past(mem_we));

   // R8: any write-back carries the reference flag
   a_r8_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> mem_wdata[REF_BIT]);

   // R9: done lasts one cycle and always carries a final status
   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r9_done_status: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 2'd0));
endmodule

// File: tb/hpt_group_search_tb_top.sv
`timescale 1ns/1ps
module hpt_group_search_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [31:0] base_addr = '0;
   logic        tbl_sel = 1'b0;
   logic [63:0] exp_tag = '0;
   logic        is_write = 1'b0;
   logic        mode64 = 1'b0;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr;
   logic [63:0] mem_wdata;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        done;
   logic [1:0]  status;
   logic [63:0] real_word;

   int checks = 0;
   int failures = 0;
   int rd_cnt = 0;
   int wr_cnt = 0;
   logic [31:0] wr_addr_last = '0;
   logic [63:0] wr_data_last = '0;
   logic [31:0] mem32 [0:255];

   always #4 clk = ~clk;

   hpt_group_search dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
      .tbl_sel(tbl_sel), .exp_tag(exp_tag), .is_write(is_write), .mode64(mode64),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .done(done), .status(status), .real_word(real_word)
   );

   always @(posedge clk) begin
      mem_rvalid <= mem_req && !mem_we && !mem_rvalid;
      if (mem_req && !mem_we && !mem_rvalid) begin
         rd_cnt <= rd_cnt + 1;
         if (mode64)
            mem_rdata <= {mem32[mem_addr[9:2]], mem32[mem_addr[9:2] + 8'd1]};
         else
            mem_rdata <= {32'h0, mem32[mem_addr[9:2]]};
      end
      if (mem_req && mem_we) begin
         wr_cnt       <= wr_cnt + 1;
         wr_addr_last <= mem_addr;
         wr_data_last <= mem_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic clear_mem();
      for (int i = 0; i < 256; i++) mem32[i] = 32'h0;
   endtask

   task automatic put_nv(input int base, input int i, input logic [31:0] w0,
                         input logic [31:0] w1);
      mem32[(base + 8*i) / 4]     = w0;
      mem32[(base + 8*i) / 4 + 1] = w1;
   endtask

   task automatic put_wd(input int base, input int i, input logic [63:0] w0,
                         input logic [63:0] w1);
      mem32[(base + 16*i) / 4]     = w0[63:32];
      mem32[(base + 16*i) / 4 + 1] = w0[31:0];
      mem32[(base + 16*i) / 4 + 2] = w1[63:32];
      mem32[(base + 16*i) / 4 + 3] = w1[31:0];
   endtask

   // Runs one search; returns reads and writes it caused
   task automatic search(input bit m64, input int base, input bit tbl,
                         input logic [63:0] tag, input bit wr,
                         output int nrd, output int nwr);
      int r0, w0c, t;
      @(negedge clk);
      r0 = rd_cnt; w0c = wr_cnt;
      mode64 = m64; base_addr = base; tbl_sel = tbl; exp_tag = tag;
      is_write = wr; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      t = 0;
      while (!done && t < 2000) begin
         @(negedge clk);
         t++;
      end
      chk(done, "R9 watchdog/done", {63'h0, done}, 64'h1);
      nrd = rd_cnt - r0;
      nwr = wr_cnt - w0c;
   endtask

   task automatic after_done_hold(input logic [1:0] st, input logic [63:0] rw);
      @(negedge clk);
      chk(!done, "R9 done one cycle", {63'h0, done}, 64'h0);
      repeat (3) @(negedge clk);
      chk(status == st, "R9 status held", {62'h0, status}, {62'h0, st});
      chk(real_word == rw, "R9 real word held", real_word, rw);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!done, "R1 done", {63'h0, done}, 64'h0);
      chk(!mem_req, "R1 mem_req", {63'h0, mem_req}, 64'h0);
      chk(status == 2'd0, "R1 status", {62'h0, status}, 64'h0);
      chk(real_word == '1, "R1 real word", real_word, '1);
   endtask

   task automatic t_nv_hit();
      int nr, nw;
      clear_mem();
      put_nv(32'h100, 1, 32'h1234_5605, 32'hFFFF_F000); // not valid
      put_nv(32'h100, 3, 32'h9234_5605, 32'h0ABC_D112); // match
      put_nv(32'h100, 5, 32'h9234_5645, 32'hFFFF_F000); // wrong hash
      put_nv(32'h100, 6, 32'h9234_5705, 32'hFFFF_F000); // wrong tag
      search(1'b0, 32'h100, 1'b0, 64'h1234_5605, 1'b0, nr, nw);
      chk(status == 2'd1, "R3 narrow hit status", {62'h0, status}, 64'h1);
      chk(real_word == 64'h0ABC_D112, "R3 narrow hit word", real_word, 64'h0ABC_D112);
      chk(nr == 16, "R6 full scan reads", nr, 16);
      chk(nw == 0, "R8 no write when flags unchanged", nw, 0);
      after_done_hold(2'd1, 64'h0ABC_D112);
   endtask

   task automatic t_nv_miss();
      int nr, nw;
      search(1'b0, 32'h100, 1'b0, 64'h1234_5606, 1'b0, nr, nw);
      chk(status == 2'd2, "R5 narrow miss status", {62'h0, status}, 64'h2);
      chk(real_word == '1, "R5 R9 miss word cleared", real_word, '1);
      chk(nr == 16, "R5 R2 miss reads", nr, 16);
      chk(nw == 0, "R5 miss no write", nw, 0);
   endtask

   task automatic t_wd_write_hit();
      int nr, nw;
      clear_mem();
      put_wd(32'h200, 2, 64'h0000_1234_5678_9A82, 64'h0000_0FFF_FFFF_F000); // not valid
      put_wd(32'h200, 4, 64'h0000_1234_5678_9A81, 64'h0000_0FFF_FFFF_F000); // wrong hash
      put_wd(32'h200, 5, 64'h0000_1234_5678_9A02 | 64'h8000_0000, 64'h0000_0EEE_EEEE_E000); // bit31 only
      put_wd(32'h200, 6, 64'h0000_1234_5678_9A83, 64'h0000_00AB_CDEF_0012); // match
      search(1'b1, 32'h200, 1'b1, 64'h0000_1234_5678_9A80, 1'b1, nr, nw);
      chk(status == 2'd1, "R4 wide hit status", {62'h0, status}, 64'h1);
      chk(real_word == 64'h0000_00AB_CDEF_0192, "R8 updated word", real_word, 64'h0000_00AB_CDEF_0192);
      chk(nw == 1, "R8 one write", nw, 1);
      chk(wr_addr_last == 32'h268, "R8 R2 write address", {32'h0, wr_addr_last}, 64'h268);
      chk(wr_data_last == 64'h0000_00AB_CDEF_0192, "R8 write data", wr_data_last, 64'h0000_00AB_CDEF_0192);
      chk(nr == 16, "R2 wide reads", nr, 16);
   endtask

   task automatic t_nv_read_ref_set();
      int nr, nw;
      clear_mem();
      put_nv(32'h100, 0, 32'h8111_1100, 32'h0004_4002);
      search(1'b0, 32'h100, 1'b0, 64'h0111_1100, 1'b0, nr, nw);
      chk(status == 2'd1, "R8 read hit status", {62'h0, status}, 64'h1);
      chk(wr_data_last == 64'h0004_4102, "R8 read sets only reference", wr_data_last, 64'h0004_4102);
      chk(wr_addr_last == 32'h104, "R8 R2 narrow write address", {32'h0, wr_addr_last}, 64'h104);
      chk(nw == 1, "R8 read hit one write", nw, 1);
   endtask

   task automatic t_nv_incons();
      int nr, nw;
      clear_mem();
      put_nv(32'h100, 2, 32'h8222_2200, 32'h0005_5100);
      put_nv(32'h100, 6, 32'h8222_2200, 32'h0006_6100);
      search(1'b0, 32'h100, 1'b0, 64'h0222_2200, 1'b1, nr, nw);
      chk(status == 2'd3, "R7 narrow inconsistent", {62'h0, status}, 64'h3);
      chk(real_word == '1, "R7 incons word", real_word, '1);
      chk(nr == 14, "R7 stops at conflict", nr, 14);
      chk(nw == 0, "R7 no write", nw, 0);
   endtask

   task automatic t_nv_consistent_dup();
      int nr, nw;
      clear_mem();
      put_nv(32'h100, 1, 32'h8333_3300, 32'h0007_7100);
      put_nv(32'h100, 4, 32'h8333_3300, 32'h0007_7184); // differs in bits 7 and 2
      search(1'b0, 32'h100, 1'b0, 64'h0333_3300, 1'b0, nr, nw);
      chk(status == 2'd1, "R7 narrow tolerant bits", {62'h0, status}, 64'h1);
      chk(real_word == 64'h0007_7100, "R6 first match wins", real_word, 64'h0007_7100);
      chk(nr == 16, "R6 scan continues", nr, 16);
   endtask

   task automatic t_wd_incons_low_bit();
      int nr, nw;
      clear_mem();
      put_wd(32'h200, 0, 64'h0000_0044_4444_4401, 64'h0000_0000_0009_9104);
      put_wd(32'h200, 7, 64'h0000_0044_4444_4401, 64'h0000_0000_0009_9100);
      search(1'b1, 32'h200, 1'b0, 64'h0000_0044_4444_4400, 1'b0, nr, nw);
      chk(status == 2'd3, "R7 wide mask includes bit 2", {62'h0, status}, 64'h3);
      chk(nw == 0, "R7 wide no write", nw, 0);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_nv_hit();
      t_nv_miss();
      t_wd_write_hit();
      t_nv_read_ref_set();
      t_nv_incons();
      t_nv_consistent_dup();
      t_wd_incons_low_bit();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule